// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire register bus: an active-high select, a serial clock and one data line. The data line is split at the block edge into an input (`sdi`) and an output (`sdo`) with its own enable (`sdo_oe`), and the pad combines them. All three bus inputs are brought into the fabric clock domain through a synchronizer chain. The serial clock's edges are then detected there, so the block runs entirely on `clk`. The serial clock must therefore be well below the fabric clock rate.

A frame is 16 bits long. It carries a register address, then a two-bit access code, then eight data bits. A write frame ends in a one-cycle strobe with the address and data on parallel outputs. A read frame presents the address, takes the register value from `rd_data` and shifts it out during the data bits. Several frames may follow each other while the select stays high. Releasing the select part way through a frame abandons it. The registered select level is provided on `cs_active`, so that a time counter can hold still during an access.

Top module: `sw3_serial_slave`

## Requirements
- R1: While `rst_n` is low, and after its release with the select low, `wr_en`, `sdo_oe` and `sdo` are 0 and `cs_active` is 0. Asserting `rst_n` low at any time, including mid-frame, returns the block to idle.
- R2: While `cs` is low, toggling `sclk` or `sdi` produces no write strobe, leaves `sdo_oe` low and leaves no partial bit count behind: the next complete frame is decoded correctly.
- R3: A frame is sampled on falling `sclk` edges after `cs` rises. The first 6 bits are the address (MSB first), the next 2 are the access code (MSB first) and the last 8 are data (MSB first). Code 01 writes `wr_data` to `reg_addr`.
- R4: A write frame raises `wr_en` for exactly one `clk` cycle after the last data bit is sampled. `reg_addr` and `wr_data` hold their values in the cycle after the strobe.
- R5: With access code 10, the value on `rd_data` for the frame's address is driven on `sdo` MSB first. Each bit changes after a rising `sclk` edge and is valid at the following falling edge.
- R6: Access codes 00 and 11 produce no write strobe and never raise `sdo_oe`.
- R7: `sdo_oe` is high only from the first data-bit rising edge of a read frame until that frame's last falling edge. It is low during address and code bits and after the frame.
- R8: If `cs` falls before the 16th bit, no write occurs and `sdo_oe` returns low. The following frame is decoded from its first bit.
- R9: Frames sent back to back within one `cs` assertion are each decoded, so a write followed by a read of the same address returns the written value.
- R10: `cs_active` follows the `cs` level after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus select, active high |
| sclk | input | 1 | Serial bus clock |
| sdi | input | 1 | Data line as seen at the pad input |
| rd_data | input | 8 | Value of the register at `reg_addr` |
| reg_addr | output | 6 | Register address of the current frame |
| wr_data | output | 8 | Write data |
| wr_en | output | 1 | One-cycle write strobe |
| sdo | output | 1 | Read data toward the pad |
| sdo_oe | output | 1 | Output enable for the data line |
| cs_active | output | 1 | Registered select level for the time counter |

## Verification
Two events can meet in one cycle: the write strobe that ends a frame, and the first bit of a following frame or the fall of the select. The bench provokes this with random back-to-back frames that keep the select high. It also drops the select after 15 bits of a write. A strobe is judged correct when exactly one fabric cycle of `wr_en` is counted per complete write frame and none for an aborted one. Reads issued right after writes in the same select assertion must return the freshly written values.

// File: rtl/sw3_pkg.sv
package sw3_pkg;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_READ  = 2'b10;
endpackage

// File: rtl/sw3_sync.sv
module sw3_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sw3_edge.sv
module sw3_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sw3_frame.sv
module sw3_frame
  import sw3_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sdi_s,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CW   = 2;
  localparam int FW   = AW + CW + DW;
  localparam int CNTW = $clog2(FW + 1);
  localparam logic [CNTW-1:0] LAST_A = CNTW'(AW - 1);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(AW + CW - 1);
  localparam logic [CNTW-1:0] LAST_F = CNTW'(FW - 1);

  logic [CNTW-1:0] bit_cnt;
  logic [DW-1:0]   sh_in;
  logic [DW-1:0]   rd_sh;
  logic [CW-1:0]   acc_q;
  logic [CW-1:0]   acc_now;
  logic            rd_mode;

  assign acc_now = {sh_in[CW-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh_in    <= '0;
      rd_sh    <= '0;
      acc_q    <= '0;
      rd_mode  <= 1'b0;
      reg_addr <= '0;
      wr_data  <= '0;
      wr_en    <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_s) begin
        bit_cnt <= '0;
        rd_mode <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        if (sclk_rise && rd_mode) begin
          sdo    <= rd_sh[DW-1];
          rd_sh  <= {rd_sh[DW-2:0], 1'b0};
          sdo_oe <= 1'b1;
        end
        if (sclk_fall) begin
          sh_in <= {sh_in[DW-2:0], sdi_s};
          if (bit_cnt == LAST_A) reg_addr <= {sh_in[AW-2:0], sdi_s};
          if (bit_cnt == LAST_C) begin
            acc_q <= acc_now;
            if (acc_now == ACC_READ) begin
              rd_mode <= 1'b1;
              rd_sh   <= rd_data;
            end
          end
          if (bit_cnt == LAST_F) begin
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            sdo_oe  <= 1'b0;
            if (acc_q == ACC_WRITE) begin
              wr_en   <= 1'b1;
              wr_data <= {sh_in[DW-2:0], sdi_s};
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sw3_serial_slave.sv
module sw3_serial_slave #(
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sclk,
  input  logic          sdi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          cs_active
);
  logic cs_s, sclk_s, sdi_s;
  logic sclk_rise, sclk_fall;

  sw3_sync #(.W(3), .STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs, sclk, sdi}), .q({cs_s, sclk_s, sdi_s})
  );

  sw3_edge i_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s),
    .rise(sclk_rise), .fall(sclk_fall)
  );

  sw3_frame #(.AW(AW), .DW(DW)) i_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_active <= 1'b0;
    else        cs_active <= cs_s;
  end
endmodule

// File: rtl/sw3_serial_slave_chk.sv
module sw3_serial_slave_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_en,
  input logic          sdo_oe,
  input logic          cs_active
);
  p_strobe_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(reg_addr) && $stable(wr_data)));

  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !wr_en);

  p_no_drive_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !sdo_oe);

  p_read_never_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !wr_en);
endmodule

bind sw3_serial_slave sw3_serial_slave_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
  .wr_en(wr_en), .sdo_oe(sdo_oe), .cs_active(cs_active)
);

// File: tb/test_sw3_serial_slave.sv
module test_sw3_serial_slave;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [5:0] reg_addr;
  logic [7:0] wr_data;
  logic       wr_en, sdo, sdo_oe, cs_active;
  logic [7:0] regs [64];
  logic [7:0] exp_regs [64];
  wire  [7:0] rd_data = regs[reg_addr];

  int total = 0, bad = 0, wr_cycles = 0;
  logic [5:0] last_a;
  logic [7:0] last_d;

  always #10 clk = ~clk;

  sw3_serial_slave i_sw3_serial_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .rd_data(rd_data), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe), .cs_active(cs_active)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      wr_cycles++;
      last_a = reg_addr;
      last_d = wr_data;
      regs[reg_addr] = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [5:0] a, input logic [1:0] c, input logic [7:0] d,
                      input int nbits, input bit hold_cs,
                      output logic [7:0] rb, output bit oe_bad);
    logic [15:0] vec = {a, c, d};
    rb = '0;
    oe_bad = 1'b0;
    if (!cs) begin
      cs = 1'b1;
      repeat (HP) @(negedge clk);
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sclk = 1'b1;
      sdi = vec[15-i];
      repeat (HP) @(negedge clk);
      if (i >= 8 && c == 2'b10) begin
        rb[15-i] = sdo;
        if (sdo_oe !== 1'b1) oe_bad = 1'b1;
      end else if (sdo_oe !== 1'b0) begin
        oe_bad = 1'b1;
      end
      sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    if (!hold_cs) begin
      cs = 1'b0;
      repeat (2 * HP) @(negedge clk);
    end
  endtask

  // full frame with checks against the bench model
  task automatic frame_chk(input logic [5:0] a, input logic [1:0] c, input logic [7:0] d,
                           input bit hold_cs, input string tag);
    int w0 = wr_cycles;
    logic [7:0] rb;
    bit oe_bad;
    logic [7:0] exp_rd = exp_regs[a];
    xfer(a, c, d, 16, hold_cs, rb, oe_bad);
    repeat (4) @(negedge clk);
    if (c == 2'b01) begin
      exp_regs[a] = d;
      chk(wr_cycles - w0 == 1, {tag, " R4 strobe cycles"}, wr_cycles - w0, 1);
      chk(last_a == a && last_d == d, {tag, " R3 write addr/data"}, {last_a, last_d}, {a, d});
    end else begin
      chk(wr_cycles == w0, {tag, " R6 no write"}, wr_cycles - w0, 0);
    end
    if (c == 2'b10) chk(rb == exp_rd, {tag, " R5 read data"}, rb, exp_rd);
    chk(!oe_bad, {tag, " R7 output enable window"}, oe_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    bit oe_bad;
    int w0;
    void'($urandom(32'd7741));
    for (int k = 0; k < 64; k++) begin
      regs[k] = 8'(k * 29 + 11);
      exp_regs[k] = 8'(k * 29 + 11);
    end

    // R1 reset state
    repeat (5) @(negedge clk);
    chk(wr_en == 0 && sdo_oe == 0 && sdo == 0 && cs_active == 0, "R1 during reset",
        {wr_en, sdo_oe, sdo, cs_active}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(wr_en == 0 && sdo_oe == 0 && sdo == 0 && cs_active == 0, "R1 after release",
        {wr_en, sdo_oe, sdo, cs_active}, 0);

    // R10 select indication
    cs = 1'b1;
    repeat (HP) @(negedge clk);
    chk(cs_active == 1, "R10 cs high", cs_active, 1);
    cs = 1'b0;
    repeat (HP) @(negedge clk);
    chk(cs_active == 0, "R10 cs low", cs_active, 0);

    // R3 / R5 directed write then read, corner values
    frame_chk(6'h3F, 2'b01, 8'hA5, 0, "dir-w1");
    frame_chk(6'h00, 2'b01, 8'h81, 0, "dir-w2");
    frame_chk(6'h3F, 2'b10, 8'h00, 0, "dir-r1");
    frame_chk(6'h00, 2'b10, 8'hFF, 0, "dir-r2");

    // R6 unused access codes
    frame_chk(6'h15, 2'b00, 8'h3C, 0, "code00");
    frame_chk(6'h2A, 2'b11, 8'hC3, 0, "code11");

    // R2 clock activity with select low
    w0 = wr_cycles;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk = 1'b1; repeat (HP) @(negedge clk);
      sclk = 1'b0; repeat (HP) @(negedge clk);
    end
    chk(wr_cycles == w0 && sdo_oe == 0, "R2 sclk ignored while deselected", wr_cycles - w0, 0);
    frame_chk(6'h12, 2'b01, 8'h5E, 0, "R2 after");

    // R8 aborted write after 15 bits, aborted read after 11 bits
    w0 = wr_cycles;
    xfer(6'h12, 2'b01, 8'hFF, 15, 0, rb, oe_bad);
    chk(wr_cycles == w0, "R8 aborted write", wr_cycles - w0, 0);
    xfer(6'h12, 2'b10, 8'h00, 11, 0, rb, oe_bad);
    chk(sdo_oe == 0, "R8 line released after abort", sdo_oe, 0);
    frame_chk(6'h12, 2'b10, 8'h00, 0, "R8 readback");

    // R9 back-to-back write/read within one select
    frame_chk(6'h07, 2'b01, 8'h69, 1, "R9 w");
    frame_chk(6'h07, 2'b10, 8'h00, 1, "R9 r");
    frame_chk(6'h08, 2'b01, 8'h96, 1, "R9 w2");
    frame_chk(6'h08, 2'b10, 8'h00, 0, "R9 r2");

    // R1 reset in mid-frame
    xfer(6'h21, 2'b01, 8'h77, 10, 1, rb, oe_bad);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_en == 0 && sdo_oe == 0 && cs_active == 0, "R1 mid-frame reset",
        {wr_en, sdo_oe, cs_active}, 0);
    cs = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
    frame_chk(6'h21, 2'b10, 8'h00, 0, "R1 after mid reset");

    // random frames, some held back to back
    for (int n = 0; n < 48; n++) begin
      logic [5:0] a = 6'($urandom % 64);
      logic [1:0] c = 2'($urandom % 4);
      logic [7:0] d = 8'($urandom % 256);
      bit hold = (($urandom % 3) == 0) && (n != 47);
      frame_chk(a, c, d, hold, "rand R3 R5 R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule